// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block moves pairs of 24-bit two's complement samples onto a three-wire audio link. The link has a bit clock, a word clock that marks the channel, and one data line. The transmitter either generates both clocks itself or follows clocks from another device. In generating mode, the system clock is taken to run at 512, 384 or 256 times the sample rate, and the frame is always 64 bit clocks long. In following mode, the block watches the incoming clocks in its own clock domain and shifts on each falling bit-clock edge it sees.

A sample pair is written with a one-cycle valid strobe and held until the next left half-frame begins. Both words of a frame therefore always come from the same pair. If no new pair arrives, the last pair is sent again. The data can be framed two ways. In I2S framing the MSB is delayed by one bit. In left-justified framing the MSB lines up with the word-clock edge. A polarity control negates each word as it is loaded into the shifter. A power-down control forces the data line low and clears the stored samples.

Top module: `aud_ser_tx`

## Requirements
- R1: While `rst_n` is low, `sdata` and `bck_out` are 0. One cycle after `pdn` is sampled high, `sdata` is 0.
- R2: In generating mode the bit-clock period is 8, 6 or 4 `clk` cycles for `mode` codes 01, 10 and 11, with the high phase lasting half the period rounded down.
- R3: In generating mode a frame is exactly 64 bit clocks, and `lrck_out` changes only in the cycle where `bck_out` falls.
- R4: With `fmt`=0 (I2S), `lrck_out` is 0 for the left word. The MSB is sent one bit clock after the word-clock edge, and the 24 bits follow MSB first.
- R5: With `fmt`=1 (left-justified), `lrck_out` is 1 for the left word. The MSB is sent in the first bit slot after the word-clock edge.
- R6: In a 64-bit frame, every bit slot of a half-frame not used by the word is 0. In I2S framing this includes the first slot.
- R7: In generating mode `sdata` changes only in the cycle where `bck_out` falls, apart from the effect of `pdn`.
- R8: `mode`=00 selects following mode. Here `bck_out`, `lrck_out` and `clk_oe` stay 0, and a 64-bit frame on `bck_in`/`lrck_in` is serialized with the chosen framing.
- R9: In following mode a 48-bit frame is accepted. With I2S framing, the LSB of each word lands in the first slot of the next half-frame.
- R10: With `invert`=1, each word is replaced by its negation when it is loaded. The most negative value 0x800000 becomes 0x7FFFFF.
- R11: A pair written with `smp_valid` is first sent in the frame whose left half starts after the write. It is repeated in later frames until it is replaced.
- R12: `pdn` clears the stored pair, so the frames after release carry zero words until a new pair is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (256/384/512 times the sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 follow external clocks; 01/10/11 generate at ratio 512/384/256 |
| fmt | input | 1 | 0 I2S framing, 1 left-justified framing |
| invert | input | 1 | Negate words at load |
| pdn | input | 1 | Power-down: data low, stored pair cleared |
| smp_valid | input | 1 | One-cycle strobe to write a sample pair |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| bck_in | input | 1 | External bit clock (following mode) |
| lrck_in | input | 1 | External word clock (following mode) |
| bck_out | output | 1 | Generated bit clock |
| lrck_out | output | 1 | Generated word clock |
| clk_oe | output | 1 | High when the block drives the link clocks |
| sdata | output | 1 | Serial data line |

## Verification
Two things happen in the same cycle at every half-frame boundary: the word-clock change, which loads a new word, and the bit-clock fall, which shifts out the next bit. In following mode the bench provokes this by driving `bck_in` low and toggling `lrck_in` on the same edge. In 48-bit I2S frames the bit shifted out at that moment must be the LSB of the word just finished, while the new word goes into the shifter. In generating mode, the bench loads a pair together with a polarity change in the right half of a frame. It then decodes the next whole frame from the link, checking that both words are negated and that every unused slot is zero.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

   localparam int DIV_W = 4;

   typedef enum logic [1:0] {
      LINK_FOLLOW = 2'b00,
      LINK_R512   = 2'b01,
      LINK_R384   = 2'b10,
      LINK_R256   = 2'b11
   } link_mode_e;

   // system clocks per bit clock for a 64-slot frame
   function automatic logic [DIV_W-1:0] clk_per_bit(input logic [1:0] m);
      case (m)
         LINK_R384: clk_per_bit = DIV_W'(6);
         LINK_R256: clk_per_bit = DIV_W'(4);
         default:   clk_per_bit = DIV_W'(8);
      endcase
   endfunction

endpackage

// File: rtl/aud_mclk_gen.sv
module aud_mclk_gen
   import aud_ser_pkg::*;
#(
   parameter int FRAME_BITS = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             fmt,
   input  logic [DIV_W-1:0] div,
   output logic             tick,
   output logic             start,
   output logic             lr_new,
   output logic             bck,
   output logic             lrck
);
   localparam int BW = $clog2(FRAME_BITS);

   logic [DIV_W-1:0] cnt, cnt_inc, hi_from;
   logic [BW-1:0]    bitc, bit_nx;

   assign cnt_inc = cnt + 1'b1;
   assign hi_from = div >> 1;
   assign bit_nx  = bitc + 1'b1;

   // a slot ends when the divider wraps; the bit clock falls on that edge
   assign tick   = run && (cnt_inc == div);
   assign start  = tick && (bit_nx[BW-2:0] == '0);
   assign lr_new = bit_nx[BW-1] ^ fmt;
   assign lrck   = run && (bitc[BW-1] ^ fmt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         bitc <= '1;
         bck  <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         bitc <= '1;
         bck  <= 1'b0;
      end else if (tick) begin
         cnt  <= '0;
         bck  <= 1'b0;
         bitc <= bit_nx;
      end else begin
         cnt  <= cnt_inc;
         bck  <= (cnt_inc >= hi_from);
      end
   end

endmodule

// File: rtl/aud_slave_sync.sv
module aud_slave_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic bck_in,
   input  logic lrck_in,
   output logic tick,
   output logic start,
   output logic lr_new
);
   logic [SYNC_STAGES:0] b_sh, l_sh;

   for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               b_sh[g] <= 1'b0;
               l_sh[g] <= 1'b0;
            end else begin
               b_sh[g] <= bck_in;
               l_sh[g] <= lrck_in;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               b_sh[g] <= 1'b0;
               l_sh[g] <= 1'b0;
            end else begin
               b_sh[g] <= b_sh[g-1];
               l_sh[g] <= l_sh[g-1];
            end
         end
      end
   end

   logic b_fall, l_chg;
   assign b_fall = b_sh[SYNC_STAGES] & ~b_sh[SYNC_STAGES-1];
   assign l_chg  = l_sh[SYNC_STAGES] ^ l_sh[SYNC_STAGES-1];

   // word clock moves on a falling bit clock, so both land as one slot event
   assign tick   = run && (b_fall || l_chg);
   assign start  = run && l_chg;
   assign lr_new = l_sh[SYNC_STAGES-1];

endmodule

// File: rtl/aud_serializer.sv
module aud_serializer #(
   parameter int W       = 24,
   parameter bit SAT_NEG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   input  logic         start,
   input  logic         fmt,
   input  logic         invert,
   input  logic [W-1:0] word,
   output logic         sdata
);
   logic [W-1:0] neg, word_n, sr;

   if (SAT_NEG) begin : g_sat
      assign neg = (word == {1'b1, {(W-1){1'b0}}}) ? {1'b0, {(W-1){1'b1}}}
                                                  : (~word + 1'b1);
   end else begin : g_wrap
      assign neg = ~word + 1'b1;
   end

   assign word_n = invert ? neg : word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr    <= '0;
         sdata <= 1'b0;
      end else if (clr) begin
         sr    <= '0;
         sdata <= 1'b0;
      end else if (tick) begin
         if (start && fmt) begin
            sdata <= word_n[W-1];
            sr    <= {word_n[W-2:0], 1'b0};
         end else if (start) begin
            sdata <= sr[W-1];
            sr    <= word_n;
         end else begin
            sdata <= sr[W-1];
            sr    <= {sr[W-2:0], 1'b0};
         end
      end
   end

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
   import aud_ser_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int FRAME_BITS  = 64,
   parameter int SYNC_STAGES = 2,
   parameter bit SAT_NEG     = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode,
   input  logic                fmt,
   input  logic                invert,
   input  logic                pdn,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   input  logic                bck_in,
   input  logic                lrck_in,
   output logic                bck_out,
   output logic                lrck_out,
   output logic                clk_oe,
   output logic                sdata
);
   localparam int BW = $clog2(FRAME_BITS);

   if ((1 << BW) != FRAME_BITS) begin : g_bad_frame
      $error("FRAME_BITS must be a power of two");
   end
   if (SAMPLE_W + 1 > FRAME_BITS / 2) begin : g_bad_width
      $error("SAMPLE_W does not fit a half-frame");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic master;
   assign master = (mode != LINK_FOLLOW);
   assign clk_oe = master;

   logic m_tick, m_start, m_lr;
   logic s_tick, s_start, s_lr;

   aud_mclk_gen #(.FRAME_BITS(FRAME_BITS)) u_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (master),
      .fmt   (fmt),
      .div   (clk_per_bit(mode)),
      .tick  (m_tick),
      .start (m_start),
      .lr_new(m_lr),
      .bck   (bck_out),
      .lrck  (lrck_out)
   );

   aud_slave_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (!master),
      .bck_in (bck_in),
      .lrck_in(lrck_in),
      .tick   (s_tick),
      .start  (s_start),
      .lr_new (s_lr)
   );

   logic tick, start, lr_new, left_sel;
   assign tick     = master ? m_tick  : s_tick;
   assign start    = master ? m_start : s_start;
   assign lr_new   = master ? m_lr    : s_lr;
   assign left_sel = (lr_new == fmt);

   // pair storage: the right word is frozen when its left partner is loaded
   logic [SAMPLE_W-1:0] hold_l, hold_r, cur_r, word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_l <= '0;
         hold_r <= '0;
         cur_r  <= '0;
      end else if (pdn) begin
         hold_l <= '0;
         hold_r <= '0;
         cur_r  <= '0;
      end else begin
         if (smp_valid) begin
            hold_l <= smp_left;
            hold_r <= smp_right;
         end
         if (tick && start && left_sel) cur_r <= hold_r;
      end
   end

   assign word = left_sel ? hold_l : cur_r;

   aud_serializer #(.W(SAMPLE_W), .SAT_NEG(SAT_NEG)) u_ser (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pdn),
      .tick  (tick),
      .start (start),
      .fmt   (fmt),
      .invert(invert),
      .word  (word),
      .sdata (sdata)
   );

endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode,
   input logic       fmt,
   input logic       pdn,
   input logic       bck_out,
   input logic       lrck_out,
   input logic       sdata
);
   logic [3:0] hi_cnt, hi_exp;

   always_comb begin
      case (mode)
         2'b10:   hi_exp = 4'd3;
         2'b11:   hi_exp = 4'd2;
         default: hi_exp = 4'd4;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_cnt <= '0;
      else if (bck_out) hi_cnt <= hi_cnt + 1'b1;
      else              hi_cnt <= '0;
   end

   assert_pdn_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pdn |=> !sdata);

   assert_bck_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bck_out) && mode != 2'b00 && $stable(mode)) |-> (hi_cnt == hi_exp));

   assert_lrck_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(lrck_out) && $stable(mode) && $stable(fmt) && mode != 2'b00)
      |-> $fell(bck_out));

   assert_data_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sdata) && !$past(pdn) && $stable(mode) && mode != 2'b00)
      |-> $fell(bck_out));

   assert_follow_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && $past(mode) == 2'b00) |-> (!bck_out && !lrck_out));

endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode    (mode),
   .fmt     (fmt),
   .pdn     (pdn),
   .bck_out (bck_out),
   .lrck_out(lrck_out),
   .sdata   (sdata)
);

// File: tb/aud_ser_tx_test.sv
`timescale 1ns/1ps
module aud_ser_tx_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode = 2'b11;
   logic fmt = 1'b0, invert = 1'b0, pdn = 1'b0, smp_valid = 1'b0;
   logic [23:0] smp_left = '0, smp_right = '0;
   logic bck_in = 1'b1, lrck_in = 1'b0;
   logic bck_out, lrck_out, clk_oe, sdata;

   always #10 clk = ~clk;

   aud_ser_tx uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .fmt(fmt), .invert(invert),
      .pdn(pdn), .smp_valid(smp_valid), .smp_left(smp_left),
      .smp_right(smp_right), .bck_in(bck_in), .lrck_in(lrck_in),
      .bck_out(bck_out), .lrck_out(lrck_out), .clk_oe(clk_oe), .sdata(sdata));

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp_v);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
      end
   endtask

   function automatic logic [23:0] negsat(input logic [23:0] w);
      if (w == 24'h800000) return 24'h7FFFFF;
      return 24'(0 - int'($signed(w)));
   endfunction

   function automatic int div_exp(input logic [1:0] m);
      return (m == 2'b01) ? 8 : (m == 2'b10) ? 6 : 4;
   endfunction

   // scoreboard
   typedef struct { int fid; logic [23:0] l; logic [23:0] r; } exp_t;
   exp_t q[$];

   logic hist [0:63];
   int pos, fid, last_rise, cyc;
   logic bprev, lrprev, lr_last, sprev, pdn_prev;

   task automatic decode_frame();
      logic [23:0] l, r;
      logic pad;
      int off;
      off = fmt ? 0 : 1;
      pad = 1'b0;
      for (int i = 0; i < 24; i++) begin
         l[23-i] = hist[off+i];
         r[23-i] = hist[32+off+i];
      end
      for (int i = 0; i < 32; i++)
         if (i < off || i >= off + 24) pad = pad | hist[i] | hist[32+i];
      chk(pad == 1'b0, "R6 unused slots", {31'd0, pad}, 32'd0);
      while (q.size() > 0 && q[0].fid < fid) begin
         chk(1'b0, "R11 frame missed", q[0].fid, fid);
         void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].fid == fid) begin
         chk(l == q[0].l, fmt ? "R5 left word" : "R4 left word", l, q[0].l);
         chk(r == q[0].r, fmt ? "R5 right word" : "R4 right word", r, q[0].r);
         void'(q.pop_front());
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         pos = -1; fid = 0; last_rise = -1; cyc = 0;
         bprev = 1'b0; lrprev = lrck_out; lr_last = ~fmt;
         sprev = sdata; pdn_prev = pdn;
      end else if (mode != 2'b00) begin
         cyc++;
         if (lrck_out !== lrprev)
            chk(bprev && !bck_out, "R3 lrck moves on bck fall", {bprev, bck_out}, 2'b10);
         if (sdata !== sprev && !pdn && !pdn_prev)
            chk(bprev && !bck_out, "R7 data moves on bck fall", {bprev, bck_out}, 2'b10);
         if (bck_out && !bprev) begin
            if (last_rise >= 0)
               chk(cyc - last_rise == div_exp(mode), "R2 bck period",
                   cyc - last_rise, div_exp(mode));
            last_rise = cyc;
            if (lrck_out != lr_last && lrck_out == fmt) begin
               if (pos >= 0) begin
                  chk(pos == 64, "R3 frame length", pos, 64);
                  if (pos == 64) decode_frame();
               end
               pos = 0;
               fid++;
            end
            if (pos >= 0 && pos < 64) hist[pos] = sdata;
            if (pos >= 0) pos++;
            lr_last = lrck_out;
         end
         bprev = bck_out; lrprev = lrck_out; sprev = sdata; pdn_prev = pdn;
      end
   end

   task automatic wait_right_half();
      while (lrck_out != fmt) @(negedge clk);
      while (lrck_out == fmt) @(negedge clk);
   endtask

   task automatic send(input logic [23:0] l, input logic [23:0] r, input bit inv);
      wait_right_half();
      smp_left = l; smp_right = r; invert = inv; smp_valid = 1'b1;
      q.push_back('{fid + 1, inv ? negsat(l) : l, inv ? negsat(r) : r});
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic expect_pair(input logic [23:0] l, input logic [23:0] r);
      wait_right_half();
      q.push_back('{fid + 1, l, r});
   endtask

   task automatic wait_frames(input int n);
      int f0;
      f0 = fid;
      while (fid < f0 + n) @(negedge clk);
   endtask

   task automatic config_link(input logic [1:0] m, input logic f);
      @(negedge clk);
      rst_n = 1'b0; mode = m; fmt = f; invert = 1'b0; pdn = 1'b0;
      bck_in = 1'b1; lrck_in = ~f;
      repeat (4) @(negedge clk);
      chk(sdata == 1'b0 && bck_out == 1'b0, "R1 reset state", {bck_out, sdata}, 0);
      rst_n = 1'b1;
   endtask

   // following mode: drive external clocks, capture data before each rise
   logic sb [0:255];
   task automatic slave_run(input int nfr, input int bpf);
      int idx;
      idx = 0;
      repeat (12) @(negedge clk);
      for (int f = 0; f < nfr; f++)
         for (int b = 0; b < bpf; b++) begin
            bck_in = 1'b0;
            if (b == 0) lrck_in = fmt;
            if (b == bpf / 2) lrck_in = ~fmt;
            repeat (7) @(negedge clk);
            sb[idx] = sdata; idx++;
            bck_in = 1'b1;
            repeat (8) @(negedge clk);
         end
   endtask

   function automatic logic exp_bit(input logic f, input int bpf, input logic [23:0] l,
                                    input logic [23:0] r, input int p_in);
      int half, h, p;
      logic [23:0] w, pw;
      half = bpf / 2; h = p_in / half; p = p_in % half;
      w = h ? r : l; pw = h ? l : r;
      if (f) return (p < 24) ? w[23-p] : 1'b0;
      if (p == 0) return (half == 24) ? pw[0] : 1'b0;
      return (p <= 24) ? w[24-p] : 1'b0;
   endfunction

   task automatic slave_case(input logic f, input int bpf, input logic [23:0] l,
                             input logic [23:0] r, input string req);
      int bad;
      config_link(2'b00, f);
      @(negedge clk);
      smp_left = l; smp_right = r; smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      chk(!bck_out && !lrck_out && !clk_oe, "R8 clocks idle", {bck_out, lrck_out, clk_oe}, 0);
      slave_run(2, bpf);
      bad = 0;
      for (int p = 0; p < bpf; p++)
         if (sb[bpf+p] !== exp_bit(f, bpf, l, r, p)) bad++;
      chk(bad == 0, req, bad, 0);
      if (bpf == 48 && !f)
         chk(sb[bpf] == r[0], "R9 LSB carried into next half", {31'd0, sb[bpf]}, {31'd0, r[0]});
   endtask

   initial begin
      int quiet_bad;
      // ratio 256, I2S
      config_link(2'b11, 1'b0);
      wait_frames(1);
      send(24'h123456, 24'hABCDEF, 1'b0);
      send(24'h800001, 24'h7FFFFF, 1'b0);
      expect_pair(24'h800001, 24'h7FFFFF);   // R11 repeat without new pair
      wait_frames(2);
      // ratio 384, left-justified
      config_link(2'b10, 1'b1);
      wait_frames(1);
      send(24'hC0FFEE, 24'h000001, 1'b0);
      send(24'h5A5A5A, 24'hFFFFFF, 1'b0);
      wait_frames(2);
      // ratio 512, I2S with polarity inversion (R10)
      config_link(2'b01, 1'b0);
      wait_frames(1);
      send(24'h123456, 24'h800000, 1'b1);
      send(24'h000001, 24'hFFFFFE, 1'b1);
      wait_frames(2);
      invert = 1'b0;
      // power-down (R12)
      config_link(2'b11, 1'b1);
      wait_frames(1);
      send(24'hA5A5A5, 24'h3C3C3C, 1'b0);
      wait_frames(2);
      pdn = 1'b1;
      @(negedge clk);
      quiet_bad = 0;
      repeat (600) begin
         @(negedge clk);
         if (sdata !== 1'b0) quiet_bad++;
      end
      chk(quiet_bad == 0, "R12 data low in power-down", quiet_bad, 0);
      pdn = 1'b0;
      expect_pair(24'h000000, 24'h000000);
      wait_frames(2);
      chk(q.size() == 0, "R11 scoreboard drained", q.size(), 0);
      // following mode
      slave_case(1'b1, 64, 24'h9ABCDE, 24'h13579B, "R8 64-slot left-justified");
      slave_case(1'b0, 48, 24'hF0E1D3, 24'h2468AD, "R9 48-slot I2S");
      slave_case(1'b0, 64, 24'h7F00FF, 24'h800001, "R8 64-slot I2S");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule